// File: doc/BRIEF.md
# Flat Page Table Translation Unit

This block maps 32-bit device addresses onto physical addresses using a one-level table in memory. The table holds one 32-bit descriptor for every 4 KB page, so the whole 4 GB device space needs 1M descriptors (4 MB). A small fully associative translation cache sits in front of the table. A request that hits is answered in the same cycle. A request that misses stalls while the block reads the descriptor through a plain memory read port, refills the cache and then answers.

Software controls the block through a small write/read register port. The registers set the table base, enable the invalidation logic, issue either a flush of every cached entry or a flush of an inclusive page range, and hold a completion flag for range flushes. The requester keeps `req_valid` and `req_vaddr` steady until it sees `rsp_valid`. A descriptor without its valid flag produces a fault response instead of a translation.

Top module: `fpt_xlate`

## Requirements
- R1: After reset no response and no memory read are pending, and the table base (register 0), the enable field (register 1) and the completion flag (register 5) all read zero.
- R2: On a miss the block raises `mem_rd_req` at address base + (virtual address bits [31:12]) × 4 and holds both the request and the address steady until `mem_rd_ack`.
- R3: A translation returns descriptor bits [31:12] joined with virtual address bits [11:0], and `rsp_nonsec` equals descriptor bit 3.
- R4: A lookup that hits a cached page gives `rsp_valid` in the cycle the request is presented, with no memory read. A miss answers two cycles after the request appears.
- R5: A fetched descriptor with bit 1 clear gives a response with `rsp_fault` set and address zero, and is not cached, so the same page fetches again on its next use.
- R6: Refills replace cache entries in round-robin order across the `ENTRIES` slots, so with 4 slots the fifth distinct page evicts the first one cached.
- R7: Writing value 2 to the command register (register 2) removes every cached entry.
- R8: Writing value 1 to the command register removes every cached entry whose page lies from the start page to the end page inclusive. The start (register 3) and end (register 4) registers keep only bits [31:12] of what is written.
- R9: A range flush sets the completion flag (register 5 reads 1). The flag then stays set until software writes zero to it, and a nonzero write leaves it unchanged.
- R10: A command acts only when register 1 bits [1:0] are both 1, and command values other than 1 and 2 do nothing. Register 1 keeps only bits [1:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, held until `rsp_valid` |
| req_vaddr | input | 32 | Device virtual address |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_paddr | output | 32 | Translated physical address (zero on fault) |
| rsp_nonsec | output | 1 | Page marked non-secure |
| rsp_fault | output | 1 | Translation fault toward the fault unit |
| mem_rd_req | output | 1 | Descriptor read request |
| mem_rd_addr | output | 32 | Descriptor byte address |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Descriptor read back |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |

## Verification
The hardest case to reach from the ports is round-robin eviction followed by a range flush that removes only some of the cached pages. The cache contents cannot be read directly, so the stimulus first fills every slot with known pages. It then pushes one more page through to force an eviction, and probes each page afterwards. Whether a memory read occurs shows which pages survived. A behavioural model of the cache contents and the replacement pointer predicts hit or miss, the read address, the delay and the result of every request.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
   localparam int unsigned VA_W  = 32;
   localparam int unsigned PG_SH = 12;
   localparam int unsigned VPN_W = VA_W - PG_SH;

   typedef logic [VPN_W-1:0] vpn_t;

   // register indices
   localparam logic [2:0] RA_BASE = 3'd0;
   localparam logic [2:0] RA_EN   = 3'd1;
   localparam logic [2:0] RA_CMD  = 3'd2;
   localparam logic [2:0] RA_LO   = 3'd3;
   localparam logic [2:0] RA_HI   = 3'd4;
   localparam logic [2:0] RA_DONE = 3'd5;

   localparam logic [31:0] CMD_RANGE = 32'h1;
   localparam logic [31:0] CMD_ALL   = 32'h2;

   localparam int unsigned DSC_VLD = 1;
   localparam int unsigned DSC_NS  = 3;

   typedef struct packed {
      logic all;
      logic range;
      vpn_t lo;
      vpn_t hi;
   } inval_t;
endpackage

// File: rtl/fpt_regs.sv
module fpt_regs
   import fpt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic [31:0] base,
   output inval_t      inv,
   output logic        done
);
   logic [31:0] base_q;
   logic [1:0]  en_q;
   vpn_t        lo_q, hi_q;
   logic        done_q;
   logic        cmd_go;

   assign cmd_go    = reg_we && (reg_addr == RA_CMD) && (en_q == 2'b11);
   assign inv.all   = cmd_go && (reg_wdata == CMD_ALL);
   assign inv.range = cmd_go && (reg_wdata == CMD_RANGE);
   assign inv.lo    = lo_q;
   assign inv.hi    = hi_q;
   assign base      = base_q;
   assign done      = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         en_q   <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         done_q <= 1'b0;
      end else begin
         if (reg_we && reg_addr == RA_BASE) base_q <= reg_wdata;
         if (reg_we && reg_addr == RA_EN)   en_q   <= reg_wdata[1:0];
         if (reg_we && reg_addr == RA_LO)   lo_q   <= reg_wdata[VA_W-1:PG_SH];
         if (reg_we && reg_addr == RA_HI)   hi_q   <= reg_wdata[VA_W-1:PG_SH];
         if (inv.range)
            done_q <= 1'b1;
         else if (reg_we && reg_addr == RA_DONE && reg_wdata == '0)
            done_q <= 1'b0;
      end
   end

   always_comb begin
      case (reg_addr)
         RA_BASE: reg_rdata = base_q;
         RA_EN:   reg_rdata = {30'd0, en_q};
         RA_LO:   reg_rdata = {lo_q, {PG_SH{1'b0}}};
         RA_HI:   reg_rdata = {hi_q, {PG_SH{1'b0}}};
         RA_DONE: reg_rdata = {31'd0, done_q};
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/fpt_tlb.sv
module fpt_tlb
   import fpt_pkg::*;
#(
   parameter int unsigned ENTRIES = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  vpn_t               lk_vpn,
   output logic               lk_hit,
   output vpn_t               lk_ppn,
   output logic               lk_ns,
   output logic [ENTRIES-1:0] hit_vec,
   input  logic               fill_en,
   input  vpn_t               fill_vpn,
   input  vpn_t               fill_ppn,
   input  logic               fill_ns,
   input  inval_t             inv
);
   localparam int unsigned IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   logic [IW-1:0] rr_q;
   vpn_t          ppn_arr [ENTRIES];
   logic [ENTRIES-1:0] ns_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rr_q <= '0;
      else if (fill_en)
         rr_q <= (rr_q == IW'(ENTRIES-1)) ? '0 : rr_q + 1'b1;
   end

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic vld_q;
      vpn_t tag_q;
      vpn_t ppn_q;
      logic ns_q;
      logic in_rng;
      logic victim;

      assign victim     = fill_en && (rr_q == IW'(i));
      assign in_rng     = (tag_q >= inv.lo) && (tag_q <= inv.hi);
      assign hit_vec[i] = vld_q && (tag_q == lk_vpn);
      assign ppn_arr[i] = ppn_q;
      assign ns_vec[i]  = ns_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            vld_q <= 1'b0;
         else if (inv.all || (inv.range && in_rng))
            vld_q <= 1'b0;
         else if (victim)
            vld_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (victim) begin
            tag_q <= fill_vpn;
            ppn_q <= fill_ppn;
            ns_q  <= fill_ns;
         end
      end
   end

   always_comb begin
      lk_ppn = '0;
      lk_ns  = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) begin
            lk_ppn = lk_ppn | ppn_arr[i];
            lk_ns  = lk_ns | ns_vec[i];
         end
      end
   end

   assign lk_hit = |hit_vec;
endmodule

// File: rtl/fpt_walker.sv
module fpt_walker
   import fpt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [31:0] req_vaddr,
   input  logic        lk_hit,
   input  vpn_t        lk_ppn,
   input  logic        lk_ns,
   input  logic [31:0] base,
   output logic        mem_rd_req,
   output logic [31:0] mem_rd_addr,
   input  logic        mem_rd_ack,
   input  logic [31:0] mem_rd_data,
   output logic        fill_en,
   output vpn_t        fill_vpn,
   output vpn_t        fill_ppn,
   output logic        fill_ns,
   output logic        rsp_valid,
   output logic [31:0] rsp_paddr,
   output logic        rsp_nonsec,
   output logic        rsp_fault
);
   typedef enum logic [1:0] {S_LOOK, S_WAIT, S_FLT} st_e;

   st_e         st_q;
   logic [31:0] addr_q;
   vpn_t        vpn_q;
   vpn_t        req_vpn;
   logic        look_hit;
   logic        unused_dsc;

   assign req_vpn    = req_vaddr[VA_W-1:PG_SH];
   assign unused_dsc = ^{mem_rd_data[PG_SH-1:DSC_NS+1], mem_rd_data[2], mem_rd_data[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_LOOK;
         addr_q <= '0;
         vpn_q  <= '0;
      end else begin
         case (st_q)
            S_LOOK: if (req_valid && !lk_hit) begin
               st_q   <= S_WAIT;
               vpn_q  <= req_vpn;
               addr_q <= base + 32'({req_vpn, 2'b00});
            end
            S_WAIT: if (mem_rd_ack)
               st_q <= mem_rd_data[DSC_VLD] ? S_LOOK : S_FLT;
            S_FLT:   st_q <= S_LOOK;
            default: st_q <= S_LOOK;
         endcase
      end
   end

   assign mem_rd_req  = (st_q == S_WAIT);
   assign mem_rd_addr = addr_q;

   assign fill_en  = (st_q == S_WAIT) && mem_rd_ack && mem_rd_data[DSC_VLD];
   assign fill_vpn = vpn_q;
   assign fill_ppn = mem_rd_data[VA_W-1:PG_SH];
   assign fill_ns  = mem_rd_data[DSC_NS];

   assign look_hit   = (st_q == S_LOOK) && req_valid && lk_hit;
   assign rsp_fault  = (st_q == S_FLT);
   assign rsp_valid  = look_hit || rsp_fault;
   assign rsp_paddr  = look_hit ? {lk_ppn, req_vaddr[PG_SH-1:0]} : '0;
   assign rsp_nonsec = look_hit && lk_ns;
endmodule

// File: rtl/fpt_xlate.sv
module fpt_xlate
   import fpt_pkg::*;
#(
   parameter int unsigned ENTRIES = 4
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [31:0] req_vaddr,
   output logic        rsp_valid,
   output logic [31:0] rsp_paddr,
   output logic        rsp_nonsec,
   output logic        rsp_fault,
   output logic        mem_rd_req,
   output logic [31:0] mem_rd_addr,
   input  logic        mem_rd_ack,
   input  logic [31:0] mem_rd_data,
   input  logic        reg_we,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("fpt_xlate: ENTRIES must be at least 2");
   end
   if (VA_W != 32 || PG_SH != 12) begin : g_bad_geom
      $error("fpt_xlate: only 32-bit addresses with 4 KB pages are supported");
   end

   logic [31:0]        tbl_base;
   inval_t             inv;
   logic               range_done;
   logic               lk_hit, lk_ns;
   vpn_t               lk_ppn;
   logic [ENTRIES-1:0] tlb_hits;
   logic               fill_en, fill_ns;
   vpn_t               fill_vpn, fill_ppn;

   fpt_regs u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .base(tbl_base), .inv(inv), .done(range_done)
   );

   fpt_tlb #(.ENTRIES(ENTRIES)) u_tlb (
      .clk(clk), .rst_n(rst_n),
      .lk_vpn(req_vaddr[VA_W-1:PG_SH]), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
      .lk_ns(lk_ns), .hit_vec(tlb_hits),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_ns(fill_ns), .inv(inv)
   );

   fpt_walker u_walk (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vaddr(req_vaddr),
      .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_ns(lk_ns), .base(tbl_base),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_ns(fill_ns),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_nonsec(rsp_nonsec), .rsp_fault(rsp_fault)
   );
endmodule

// File: rtl/fpt_xlate_chk.sv
module fpt_xlate_chk #(
   parameter int unsigned ENTRIES = 4
)(
   input logic               clk,
   input logic               rst_n,
   input logic               mem_rd_req,
   input logic               mem_rd_ack,
   input logic [31:0]        mem_rd_addr,
   input logic               rsp_valid,
   input logic               rsp_fault,
   input logic [ENTRIES-1:0] hit_vec,
   input logic               done,
   input logic               reg_we,
   input logic [2:0]         reg_addr,
   input logic [31:0]        reg_wdata
);
   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req && !mem_rd_ack |=> mem_rd_req);

   a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req && !mem_rd_ack |=> $stable(mem_rd_addr));

   a_r2_no_rsp_while_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !rsp_valid);

   a_r4_hit_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault |-> !mem_rd_req);

   a_r5_fault_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_fault) |-> $past(mem_rd_req && mem_rd_ack));

   a_r6_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done && !(reg_we && reg_addr == 3'd5 && reg_wdata == 32'd0) |=> done);
endmodule

bind fpt_xlate fpt_xlate_chk #(.ENTRIES(ENTRIES)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .mem_rd_req(mem_rd_req), .mem_rd_ack(mem_rd_ack), .mem_rd_addr(mem_rd_addr),
   .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
   .hit_vec(tlb_hits), .done(range_done),
   .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/fpt_xlate_bench.sv
`timescale 1ns/1ps
module fpt_xlate_bench;
   localparam int ENT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        rsp_valid, rsp_nonsec, rsp_fault, mem_rd_req;
   logic [31:0] rsp_paddr, mem_rd_addr, reg_rdata;
   logic        mem_rd_ack = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;

   int n_cmp = 0;
   int n_bad = 0;

   // memory image of descriptors, keyed by byte address
   logic [31:0] dmem [int unsigned];

   // behavioural model
   bit          m_vld [ENT];
   logic [19:0] m_tag [ENT];
   logic [19:0] m_ppn [ENT];
   bit          m_ns  [ENT];
   int          m_rr = 0;
   logic [31:0] m_base = '0;
   logic [1:0]  m_en = '0;
   logic [19:0] m_lo = '0, m_hi = '0;
   bit          m_done = 0;

   always #2.5 clk = ~clk;

   fpt_xlate #(.ENTRIES(ENT)) u_fpt_xlate (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vaddr(req_vaddr),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_nonsec(rsp_nonsec), .rsp_fault(rsp_fault),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   // memory responder: acknowledges one cycle after seeing a request
   always @(negedge clk) begin
      if (mem_rd_req && !mem_rd_ack) begin
         mem_rd_ack  <= 1'b1;
         mem_rd_data <= dmem.exists(mem_rd_addr) ? dmem[mem_rd_addr] : 32'd0;
      end else begin
         mem_rd_ack  <= 1'b0;
      end
   end

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   function automatic logic [31:0] dsc(input logic [31:0] pa, input bit vld, input bit ns);
      return {pa[31:12], 8'd0, ns, 1'b0, vld, 1'b0};
   endfunction

   task automatic put(input logic [31:0] va, input logic [31:0] d);
      dmem[m_base + {10'd0, va[31:12], 2'b00}] = d;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      case (a)
         3'd0: m_base = d;
         3'd1: m_en = d[1:0];
         3'd3: m_lo = d[31:12];
         3'd4: m_hi = d[31:12];
         3'd5: if (d == 0) m_done = 0;
         3'd2: if (m_en == 2'b11) begin
            if (d == 32'h2)
               for (int i = 0; i < ENT; i++) m_vld[i] = 0;
            else if (d == 32'h1) begin
               for (int i = 0; i < ENT; i++)
                  if (m_tag[i] >= m_lo && m_tag[i] <= m_hi) m_vld[i] = 0;
               m_done = 1;
            end
         end
         default: ;
      endcase
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string rq);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(rq, $sformatf("reg%0d", a), reg_rdata, exp);
   endtask

   // translate one address and compare with the model
   task automatic xl(input logic [31:0] va, input string rq);
      logic [19:0] vpn;
      logic [31:0] exp_addr, d;
      int idx, cyc;
      bit fetched;
      logic [31:0] faddr;
      vpn = va[31:12];
      idx = -1;
      for (int i = 0; i < ENT; i++) if (m_vld[i] && m_tag[i] == vpn) idx = i;
      exp_addr = m_base + {10'd0, vpn, 2'b00};
      d = dmem.exists(exp_addr) ? dmem[exp_addr] : 32'd0;
      fetched = 0; faddr = '0; cyc = 0;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va;
      #1;
      while (!rsp_valid && cyc < 40) begin
         if (mem_rd_req && !fetched) begin fetched = 1; faddr = mem_rd_addr; end
         if (idx >= 0) chk("R4", "read on hit", {31'd0, mem_rd_req}, 32'd0);
         @(negedge clk); #1; cyc++;
      end
      if (idx >= 0) begin
         chk("R4", "hit latency", cyc, 0);
         chk("R3", "hit paddr", rsp_paddr, {m_ppn[idx], va[11:0]});
         chk("R3", "hit nonsec", {31'd0, rsp_nonsec}, {31'd0, m_ns[idx]});
         chk("R4", "hit fault", {31'd0, rsp_fault}, 32'd0);
      end else begin
         chk("R2", "miss fetched", {31'd0, fetched}, 32'd1);
         chk("R2", "fetch addr", faddr, exp_addr);
         chk("R4", "miss latency", cyc, 2);
         if (d[1]) begin
            chk("R3", "miss paddr", rsp_paddr, {d[31:12], va[11:0]});
            chk("R3", "miss nonsec", {31'd0, rsp_nonsec}, {31'd0, d[3]});
            chk("R5", "no fault", {31'd0, rsp_fault}, 32'd0);
            m_vld[m_rr] = 1; m_tag[m_rr] = vpn; m_ppn[m_rr] = d[31:12]; m_ns[m_rr] = d[3];
            m_rr = (m_rr + 1) % ENT;
         end else begin
            chk("R5", "fault flag", {31'd0, rsp_fault}, 32'd1);
            chk("R5", "fault paddr", rsp_paddr, 32'd0);
         end
      end
      chk(rq, "responded", {31'd0, rsp_valid}, 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < ENT; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_ppn[i] = '0; m_ns[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
      chk("R1", "mem_rd_req", {31'd0, mem_rd_req}, 32'd0);
      rd(3'd0, 32'd0, "R1");
      rd(3'd1, 32'd0, "R1");
      rd(3'd5, 32'd0, "R1");

      wr(3'd0, 32'h8000_0000);
      rd(3'd0, 32'h8000_0000, "R2");
      put(32'h0001_2000, dsc(32'h3456_7000, 1, 1));
      put(32'h0001_3000, dsc(32'h0ABC_D000, 1, 0));
      put(32'h0001_4000, dsc(32'h1111_1000, 1, 0));
      put(32'h0001_5000, dsc(32'h2222_2000, 1, 1));
      put(32'h0001_6000, dsc(32'h3333_3000, 1, 0));
      put(32'hFFFF_F000, dsc(32'hFEDC_B000, 1, 1));
      put(32'h0002_0000, 32'h0000_0008);   // non-secure but not valid

      // R2/R3 miss then R4 hit
      xl(32'h0001_2345, "R2");
      xl(32'h0001_2ABC, "R4");
      // R5 invalid descriptor, twice: not cached
      xl(32'h0002_0010, "R5");
      xl(32'h0002_0FFF, "R5");
      // R6 fill all slots, then evict
      xl(32'h0001_3000, "R6");
      xl(32'h0001_4004, "R6");
      xl(32'h0001_5008, "R6");
      xl(32'h0001_600C, "R6");   // evicts page 0x12
      xl(32'h0001_3FFF, "R6");   // still cached
      xl(32'h0001_2000, "R6");   // refetch, evicts 0x13
      xl(32'h0001_3123, "R6");   // refetch
      xl(32'hFFFF_FFFF, "R3");   // top page

      // R10 commands without enables, and unknown command value
      wr(3'd2, 32'h2);
      wr(3'd1, 32'hFFFF_FFFD);
      rd(3'd1, 32'h1, "R10");
      wr(3'd2, 32'h2);
      xl(32'h0001_3000, "R10");
      wr(3'd1, 32'h3);
      wr(3'd2, 32'h5);
      rd(3'd5, 32'd0, "R10");
      xl(32'h0001_2000, "R10");

      // R8 range flush with masked bounds
      wr(3'd3, 32'h0001_2FFF);
      wr(3'd4, 32'h0001_3123);
      rd(3'd3, 32'h0001_2000, "R8");
      rd(3'd4, 32'h0001_3000, "R8");
      wr(3'd2, 32'h1);
      rd(3'd5, 32'd1, "R9");
      xl(32'hFFFF_F000, "R8");   // outside range, still cached
      xl(32'h0001_2000, "R8");   // inside, refetch
      xl(32'h0001_3000, "R8");   // end page inclusive, refetch

      // R9 completion flag handling
      wr(3'd5, 32'h7);
      rd(3'd5, 32'd1, "R9");
      wr(3'd5, 32'd0);
      rd(3'd5, 32'd0, "R9");

      // R7 flush everything
      xl(32'h0001_5000, "R7");
      wr(3'd2, 32'h2);
      rd(3'd5, 32'd0, "R7");
      put(32'h0001_5000, dsc(32'h4444_4000, 1, 0));
      xl(32'h0001_5010, "R7");
      xl(32'hFFFF_F000, "R7");
      xl(32'h0001_5020, "R7");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule